// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 32-bit physical address. With translation switched off it hands the virtual address straight back and reads no memory. With translation switched on it reads one word from a page directory. If that entry maps a 4 MB region directly, the walk stops there. Otherwise it reads one word from a page table. It combines the access rights found at both levels and either returns the physical address or raises a fault. On a fault it records the virtual address that caused it.

A requester presents a virtual address, the access type (read or write) and the current privilege level with a valid/ready handshake. The configuration inputs are sampled in the cycle the request is accepted:

- the directory base register;
- the translation enable;
- the large-mapping enable;
- the supervisor write-protect bit.

Table entries are fetched through a single-word read port. That port has a valid/ready request channel and a one-cycle data-valid response, and the walker waits in place for any number of stall cycles on either channel. Completion is a one-cycle done pulse. It carries the physical address, or a fault flag with the physical address forced to zero.

The controller is a six-state machine:

- IDLE accepts a request. It goes to FINISH when translation is off (PASS transition) and to DIR_REQ when it is on (WALK transition).
- DIR_REQ drives the directory read until it is taken (DIR_ISSUE transition to DIR_WAIT).
- DIR_WAIT waits for the directory word. It goes to FINISH on a missing entry (DIR_MISS). It also goes to FINISH on a large mapping (DIR_LARGE), with a result or a fault. Otherwise it goes to TBL_REQ (DIR_NEXT).
- TBL_REQ drives the table read until it is taken (TBL_ISSUE transition to TBL_WAIT).
- TBL_WAIT waits for the table word and goes to FINISH with a result or a fault (TBL_DONE).
- FINISH pulses done and returns to IDLE (RETIRE).

Top module: `pgwalk_top`

## Requirements
- R1: When the translation enable is 0 at acceptance, done rises in the cycle after acceptance with paddr equal to the virtual address and fault 0, and no memory read is issued.
- R2: The first read of a walk is at address {base[31:12], 12'h000} + vaddr[31:22]*4. Base bits 11:0 have no effect.
- R3: For a two-level walk the second read is at {dir_entry[31:12], 12'h000} + vaddr[21:12]*4. A successful result is {table_entry[31:12], vaddr[11:0]}.
- R4: A directory entry with bit 0 (present) equal to 0 ends the walk with a fault after that single read.
- R5: A table entry with bit 0 (present) equal to 0 ends the walk with a fault.
- R6: When directory entry bit 7 is 1 and the large-mapping enable is 1, the walk ends after one read with result {dir_entry[31:22], vaddr[21:0]}. With the enable at 0, bit 7 is ignored and a two-level walk takes place.
- R7: An access at privilege level 3 faults unless bit 2 (user) is 1 in every entry used by the walk. Levels 0 to 2 are never refused on this bit.
- R8: A write faults when bit 1 (writable) is 0 in any entry used, if the access is at level 3 or the write-protect input is 1. At levels 0 to 2 with write-protect 0, writes are never refused on this bit.
- R9: On a fault, done and fault are 1 together and paddr is 0. fault_vaddr takes the faulting virtual address and changes at no other time.
- R10: req_ready is 0 from acceptance until done, and done lasts one cycle. A stalled memory request holds its address. Any number of stall cycles on the request or response channel leaves the result unchanged.
- R11: After reset req_ready is 1, and done, fault, mem_req_valid, paddr and fault_vaddr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 32 | Directory base register; bits 31:12 used |
| cfg_paging_en | input | 1 | Translation enable |
| cfg_large_en | input | 1 | Large 4 MB mapping enable |
| cfg_wp | input | 1 | Supervisor write-protect |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_cpl | input | 2 | Current privilege level, 3 is user |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Entry read request accepted |
| mem_req_addr | output | 32 | Entry word address (byte address) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion is a fault |
| paddr | output | 32 | Physical address, 0 on fault |
| fault_vaddr | output | 32 | Last faulting virtual address |

## Verification
The hardest case to reach is the split-permission case. The directory grants a right and the table withholds it, or the reverse. This must happen while the large-mapping bit is set but disabled, and while the read port stalls at a varying phase. The bench builds a synthetic directory and table set whose present, writable, user and size bits follow different residues of the entry index. It then sweeps directory indices, table indices and all sixteen combinations of write, privilege, write-protect and large enable, so every mix of level rights occurs. The read port's ready gaps and response latency follow a free-running counter, so each walk meets the stalls at a different phase.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_FINISH
    } walk_state_e;

    typedef enum logic [2:0] {
        RES_NONE,
        RES_DIRECT,
        RES_LARGE,
        RES_SMALL,
        RES_FAULT
    } walk_result_e;

    localparam int unsigned BIT_PRESENT  = 0;
    localparam int unsigned BIT_WRITABLE = 1;
    localparam int unsigned BIT_USER     = 2;
    localparam int unsigned BIT_LARGE    = 7;

    localparam logic [1:0] USER_CPL = 2'd3;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [ADDR_W-1:0]       vaddr,
    input  logic [ADDR_W-OFF_W-1:0] pde_frame,
    input  logic [ADDR_W-OFF_W-1:0] rsp_frame,
    output logic [ADDR_W-1:0]       dir_entry_addr,
    output logic [ADDR_W-1:0]       tbl_entry_addr,
    output logic [ADDR_W-1:0]       small_paddr,
    output logic [ADDR_W-1:0]       large_paddr
);
    localparam int BIG_OFF_W = IDX_W + OFF_W;
    localparam int ENT_SHIFT = 2;

    logic [ADDR_W-1:0] dir_base;
    logic [ADDR_W-1:0] tbl_base;
    logic [ADDR_W-1:0] dir_off;
    logic [ADDR_W-1:0] tbl_off;

    assign dir_base = {base_frame, {OFF_W{1'b0}}};
    assign tbl_base = {pde_frame, {OFF_W{1'b0}}};
    assign dir_off  = ADDR_W'(vaddr[ADDR_W-1:BIG_OFF_W]) << ENT_SHIFT;
    assign tbl_off  = ADDR_W'(vaddr[BIG_OFF_W-1:OFF_W]) << ENT_SHIFT;

    assign dir_entry_addr = dir_base + dir_off;
    assign tbl_entry_addr = tbl_base + tbl_off;
    assign small_paddr    = {rsp_frame, vaddr[OFF_W-1:0]};
    assign large_paddr    = {rsp_frame[ADDR_W-OFF_W-1:IDX_W], vaddr[BIG_OFF_W-1:0]};

endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm (
    input  logic pde_w,
    input  logic pde_u,
    input  logic pte_w,
    input  logic pte_u,
    input  logic use_pte,
    input  logic is_write,
    input  logic is_user,
    input  logic wp,
    output logic allow
);
    logic eff_w;
    logic eff_u;
    logic user_deny;
    logic write_deny;

    always_comb begin
        eff_w      = pde_w & (pte_w | ~use_pte);
        eff_u      = pde_u & (pte_u | ~use_pte);
        user_deny  = is_user & ~eff_u;
        write_deny = is_write & ~eff_w & (is_user | wp);
        allow      = ~user_deny & ~write_deny;
    end

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
    import pgwalk_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         paging_en,
    input  logic         mem_req_ready,
    input  logic         mem_rsp_valid,
    input  logic         rsp_present,
    input  logic         dir_large,
    input  logic         dir_allow,
    input  logic         tbl_allow,
    output walk_state_e  state,
    output logic         req_ready,
    output logic         mem_req_valid,
    output logic         use_tbl_addr,
    output logic         done,
    output logic         load_req,
    output logic         load_pde,
    output walk_result_e result
);
    walk_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt           = state;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        use_tbl_addr  = 1'b0;
        done          = 1'b0;
        load_req      = 1'b0;
        load_pde      = 1'b0;
        result        = RES_NONE;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    load_req = 1'b1;
                    if (!paging_en) begin
                        result = RES_DIRECT;
                        nxt    = ST_FINISH;
                    end else begin
                        nxt    = ST_DIR_REQ;
                    end
                end
            end
            ST_DIR_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    nxt = ST_DIR_WAIT;
                end
            end
            ST_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!rsp_present) begin
                        result = RES_FAULT;
                        nxt    = ST_FINISH;
                    end else if (dir_large) begin
                        result = dir_allow ? RES_LARGE : RES_FAULT;
                        nxt    = ST_FINISH;
                    end else begin
                        load_pde = 1'b1;
                        nxt      = ST_TBL_REQ;
                    end
                end
            end
            ST_TBL_REQ: begin
                mem_req_valid = 1'b1;
                use_tbl_addr  = 1'b1;
                if (mem_req_ready) begin
                    nxt = ST_TBL_WAIT;
                end
            end
            ST_TBL_WAIT: begin
                use_tbl_addr = 1'b1;
                if (mem_rsp_valid) begin
                    result = (rsp_present && tbl_allow) ? RES_SMALL : RES_FAULT;
                    nxt    = ST_FINISH;
                end
            end
            ST_FINISH: begin
                done = 1'b1;
                nxt  = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int IDX_W         = 10,
    parameter int OFF_W         = 12,
    parameter bit LARGE_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_paging_en,
    input  logic              cfg_large_en,
    input  logic              cfg_wp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [1:0]        req_cpl,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] paddr,
    output logic [ADDR_W-1:0] fault_vaddr
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_state_e  state;
    walk_result_e result;
    logic         use_tbl_addr;
    logic         load_req;
    logic         load_pde;
    logic         dir_large;
    logic         dir_allow;
    logic         tbl_allow;

    logic [ADDR_W-1:0]  vaddr_q;
    logic [FRAME_W-1:0] base_q;
    logic               write_q;
    logic               user_q;
    logic               wp_q;
    logic               large_en_q;
    logic [FRAME_W-1:0] pde_frame_q;
    logic               pde_w_q;
    logic               pde_u_q;
    logic [ADDR_W-1:0]  paddr_q;
    logic               fault_q;
    logic [ADDR_W-1:0]  fault_vaddr_q;

    logic [ADDR_W-1:0] dir_entry_addr;
    logic [ADDR_W-1:0] tbl_entry_addr;
    logic [ADDR_W-1:0] small_paddr;
    logic [ADDR_W-1:0] large_paddr;

    logic unused_bits;
    assign unused_bits = ^{cfg_base[OFF_W-1:0],
                           mem_rsp_data[OFF_W-1:BIT_LARGE+1],
                           mem_rsp_data[BIT_LARGE-1:BIT_USER+1],
                           state};

    pgwalk_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .paging_en     (cfg_paging_en),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_present   (mem_rsp_data[BIT_PRESENT]),
        .dir_large     (dir_large),
        .dir_allow     (dir_allow),
        .tbl_allow     (tbl_allow),
        .state         (state),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .use_tbl_addr  (use_tbl_addr),
        .done          (done),
        .load_req      (load_req),
        .load_pde      (load_pde),
        .result        (result)
    );

    pgwalk_addr #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) u_addr (
        .base_frame     (base_q),
        .vaddr          (vaddr_q),
        .pde_frame      (pde_frame_q),
        .rsp_frame      (mem_rsp_data[ADDR_W-1:OFF_W]),
        .dir_entry_addr (dir_entry_addr),
        .tbl_entry_addr (tbl_entry_addr),
        .small_paddr    (small_paddr),
        .large_paddr    (large_paddr)
    );

    pgwalk_perm u_perm_large (
        .pde_w    (mem_rsp_data[BIT_WRITABLE]),
        .pde_u    (mem_rsp_data[BIT_USER]),
        .pte_w    (1'b1),
        .pte_u    (1'b1),
        .use_pte  (1'b0),
        .is_write (write_q),
        .is_user  (user_q),
        .wp       (wp_q),
        .allow    (dir_allow)
    );

    pgwalk_perm u_perm_small (
        .pde_w    (pde_w_q),
        .pde_u    (pde_u_q),
        .pte_w    (mem_rsp_data[BIT_WRITABLE]),
        .pte_u    (mem_rsp_data[BIT_USER]),
        .use_pte  (1'b1),
        .is_write (write_q),
        .is_user  (user_q),
        .wp       (wp_q),
        .allow    (tbl_allow)
    );

    generate
        if (LARGE_SUPPORT) begin : g_large
            assign dir_large = mem_rsp_data[BIT_LARGE] & large_en_q;
        end else begin : g_no_large
            logic unused_large;
            assign unused_large = mem_rsp_data[BIT_LARGE] ^ large_en_q;
            assign dir_large    = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q       <= '0;
            base_q        <= '0;
            write_q       <= 1'b0;
            user_q        <= 1'b0;
            wp_q          <= 1'b0;
            large_en_q    <= 1'b0;
            pde_frame_q   <= '0;
            pde_w_q       <= 1'b0;
            pde_u_q       <= 1'b0;
            paddr_q       <= '0;
            fault_q       <= 1'b0;
            fault_vaddr_q <= '0;
        end else begin
            if (load_req) begin
                vaddr_q    <= req_vaddr;
                base_q     <= cfg_base[ADDR_W-1:OFF_W];
                write_q    <= req_write;
                user_q     <= (req_cpl == USER_CPL);
                wp_q       <= cfg_wp;
                large_en_q <= cfg_large_en;
            end
            if (load_pde) begin
                pde_frame_q <= mem_rsp_data[ADDR_W-1:OFF_W];
                pde_w_q     <= mem_rsp_data[BIT_WRITABLE];
                pde_u_q     <= mem_rsp_data[BIT_USER];
            end
            unique case (result)
                RES_DIRECT: begin
                    paddr_q <= req_vaddr;
                    fault_q <= 1'b0;
                end
                RES_LARGE: begin
                    paddr_q <= large_paddr;
                    fault_q <= 1'b0;
                end
                RES_SMALL: begin
                    paddr_q <= small_paddr;
                    fault_q <= 1'b0;
                end
                RES_FAULT: begin
                    paddr_q       <= '0;
                    fault_q       <= 1'b1;
                    fault_vaddr_q <= vaddr_q;
                end
                default: begin
                end
            endcase
        end
    end

    assign mem_req_addr = use_tbl_addr ? tbl_entry_addr : dir_entry_addr;
    assign paddr        = paddr_q;
    assign fault        = fault_q & done;
    assign fault_vaddr  = fault_vaddr_q;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cfg_paging_en,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              done,
    input logic              fault,
    input logic [ADDR_W-1:0] paddr,
    input logic [ADDR_W-1:0] fault_vaddr
);
    AST_PASS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_paging_en) |=> (done && !mem_req_valid)); // R1

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R10

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && paddr == '0)); // R9

    AST_FVA_ONLY_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_vaddr) |-> (done && fault)); // R9

endmodule

bind pgwalk_top pgwalk_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .cfg_paging_en (cfg_paging_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr),
    .fault_vaddr   (fault_vaddr)
);

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;

    localparam logic [31:0] DIR_BASE = 32'h0010_0000;
    localparam logic [31:0] BASE_REG = 32'h0010_0ABC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = BASE_REG;
    logic        cfg_paging_en = 1'b0;
    logic        cfg_large_en = 1'b0;
    logic        cfg_wp = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpl = 2'd0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic        fault;
    logic [31:0] paddr;
    logic [31:0] fault_vaddr;

    int          n_checks = 0;
    int          n_errors = 0;
    int          n_reads = 0;
    logic [31:0] rd_addr [2];
    logic [31:0] last_fault_va = '0;

    always #2.5 clk = ~clk;

    pgwalk_top uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_base      (cfg_base),
        .cfg_paging_en (cfg_paging_en),
        .cfg_large_en  (cfg_large_en),
        .cfg_wp        (cfg_wp),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .req_cpl       (req_cpl),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done          (done),
        .fault         (fault),
        .paddr         (paddr),
        .fault_vaddr   (fault_vaddr)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Synthetic tables: directory words at DIR_BASE, table words anywhere else.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] i;
        logic [31:0] h;
        logic [19:0] fr;
        if (a >= DIR_BASE && a < DIR_BASE + 32'd4096) begin
            i  = (a - DIR_BASE) >> 2;
            fr = 20'h80000 + 20'(i * 3);
            return {fr, 4'b0, (i % 6 == 1), 4'b0, (i % 3 != 2), (i % 4 != 3), (i % 9 != 4)};
        end
        h  = a >> 2;
        fr = 20'(h * 40503) ^ 20'h5A5A5;
        return {fr, 4'b0, 1'b0, 4'b0, (h % 7 != 3), (h % 5 != 2), (h % 11 != 7)};
    endfunction

    // Memory port model: ready gaps and response latency follow a tick counter.
    initial begin : responder
        int          tick = 0;
        logic        pend = 1'b0;
        int          lat = 0;
        logic [31:0] p_addr = '0;
        logic        vld_prev = 1'b0;
        logic [31:0] addr_prev = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (vld_prev && mem_req_ready) begin
                pend   = 1'b1;
                lat    = tick % 3;
                p_addr = addr_prev;
                if (n_reads < 2) rd_addr[n_reads] = addr_prev;
                n_reads++;
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(p_addr);
                    pend          = 1'b0;
                end else begin
                    lat--;
                end
            end
            mem_req_ready = !pend && ((tick % 4) != 2);
            vld_prev      = mem_req_valid;
            addr_prev     = mem_req_addr;
            tick++;
        end
    end

    task automatic expect_walk(input logic [31:0] va, input logic wr, input logic [1:0] cpl,
                               input logic pg, input logic lg, input logic wp,
                               output logic [31:0] e_pa, output logic e_flt, output int e_rd,
                               output logic [31:0] a1, output logic [31:0] a2, output string tag);
        logic [31:0] pde;
        logic [31:0] pte;
        logic        usr;
        logic        ok_u;
        logic        ok_w;
        logic        deny;
        usr = (cpl == 2'd3);
        a1 = '0;
        a2 = '0;
        if (!pg) begin
            e_pa = va; e_flt = 1'b0; e_rd = 0; tag = "R1";
            return;
        end
        a1  = DIR_BASE + {20'd0, va[31:22], 2'b00};
        pde = mem_word(a1);
        if (!pde[0]) begin
            e_pa = '0; e_flt = 1'b1; e_rd = 1; tag = "R4";
            return;
        end
        if (lg && pde[7]) begin
            ok_u = pde[2];
            ok_w = pde[1];
            e_rd = 1;
            deny = (usr && !ok_u) || (wr && !ok_w && (usr || wp));
            e_flt = deny;
            e_pa  = deny ? 32'd0 : {pde[31:22], va[21:0]};
            tag = deny ? ((usr && !ok_u) ? "R7" : "R8") : "R6";
            return;
        end
        a2  = {pde[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
        pte = mem_word(a2);
        e_rd = 2;
        if (!pte[0]) begin
            e_pa = '0; e_flt = 1'b1; tag = "R5";
            return;
        end
        ok_u = pde[2] & pte[2];
        ok_w = pde[1] & pte[1];
        deny = (usr && !ok_u) || (wr && !ok_w && (usr || wp));
        e_flt = deny;
        e_pa  = deny ? 32'd0 : {pte[31:12], va[11:0]};
        if (deny) tag = (usr && !ok_u) ? "R7" : "R8";
        else tag = (pde[7] && !lg) ? "R6" : "R3";
    endtask

    task automatic walk(input logic [31:0] va, input logic wr, input logic [1:0] cpl,
                        input logic pg, input logic lg, input logic wp);
        logic [31:0] e_pa;
        logic        e_flt;
        int          e_rd;
        logic [31:0] a1;
        logic [31:0] a2;
        string       tag;
        int          wcnt;
        expect_walk(va, wr, cpl, pg, lg, wp, e_pa, e_flt, e_rd, a1, a2, tag);
        @(negedge clk);
        check(done == 1'b0, "R10", "done single pulse", {31'd0, done}, 32'd0);
        check(req_ready == 1'b1, "R10", "ready when idle", {31'd0, req_ready}, 32'd1);
        n_reads = 0;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_cpl = cpl;
        cfg_paging_en = pg; cfg_large_en = lg; cfg_wp = wp;
        @(negedge clk);
        req_valid = 1'b0;
        wcnt = 0;
        while (!done && wcnt < 200) begin
            if (req_ready) check(1'b0, "R10", "ready during walk", 32'd1, 32'd0);
            @(negedge clk);
            wcnt++;
        end
        check(done == 1'b1, "R10", "walk completes", {31'd0, done}, 32'd1);
        if (!pg) check(wcnt == 0, "R1", "pass-through latency", wcnt, 32'd0);
        check(fault == e_flt, tag, "fault flag", {31'd0, fault}, {31'd0, e_flt});
        check(paddr == e_pa, tag, "physical address", paddr, e_pa);
        check(n_reads == e_rd, tag, "read count", n_reads, e_rd);
        if (e_rd >= 1 && n_reads >= 1) check(rd_addr[0] == a1, "R2", "directory entry address", rd_addr[0], a1);
        if (e_rd == 2 && n_reads == 2) check(rd_addr[1] == a2, "R3", "table entry address", rd_addr[1], a2);
        if (e_flt) last_fault_va = va;
        check(fault_vaddr == last_fault_va, "R9", "fault address register", fault_vaddr, last_fault_va);
    endtask

    initial begin : watchdog
        #(5.0 * 190000);
        n_checks++;
        n_errors++;
        $display("FAIL R10 watchdog expired: actual %h expected %h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : stimulus
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1, "R11", "reset req_ready", {31'd0, req_ready}, 32'd1);
        check(done == 1'b0, "R11", "reset done", {31'd0, done}, 32'd0);
        check(fault == 1'b0, "R11", "reset fault", {31'd0, fault}, 32'd0);
        check(mem_req_valid == 1'b0, "R11", "reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        check(paddr == 32'd0, "R11", "reset paddr", paddr, 32'd0);
        check(fault_vaddr == 32'd0, "R11", "reset fault_vaddr", fault_vaddr, 32'd0);

        // R1 pass-through at several addresses and access kinds
        for (int p = 0; p < 8; p++) begin
            walk(32'hFFFF_FFFF - 32'(p * 32'h1357_9BDF), p[0], p[1] ? 2'd3 : 2'd0, 1'b0, p[2], p[0]);
        end

        // Sweep: directory indices x table indices x access/config combinations
        for (int k = 0; k < 36; k++) begin
            for (int t = 0; t < 3; t++) begin
                for (int c = 0; c < 16; c++) begin
                    logic [9:0]  di;
                    logic [9:0]  tj;
                    logic [11:0] off;
                    di  = (k == 35) ? 10'd1023 : 10'(k);
                    tj  = (t == 0) ? 10'd0 : ((t == 1) ? 10'd517 : 10'd1023);
                    off = 12'(k * 37 + t * 1365 + c);
                    walk({di, tj, off}, c[0], c[1] ? 2'd3 : 2'(c % 3), 1'b1, c[3], c[2]);
                end
            end
        end

        // Pass-through after faults must not disturb fault_vaddr (R9)
        walk(32'h1234_5678, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule